// File: doc/BRIEF.md
# Conversion-Trigger Prescaler

This block turns a stream of timing events from a PWM time base into periodic start-of-conversion pulses for an ADC. It has two independent trigger channels, and each channel is configured separately. The channel picks one event source. That source is one of the counter zero or period events, a compare event chosen through an alternate-compare bit, or that channel's own digital-compare trigger. The channel counts occurrences of the chosen event, and a software force strobe counts as one extra occurrence. When the count reaches a programmed period, the channel emits a one-cycle trigger pulse and latches a flag.

Each channel has a narrow mode, which uses a 2-bit period (one pulse every 1 to 3 events), and a wide mode, which uses a 4-bit period (every 1 to 15 events). In wide mode the counter can be preloaded with a programmed value on a sync event or on a software force. Pulses keep coming whether or not the flag has been cleared. Disabling a channel only holds back the pulse: the channel goes on counting up to the period, then waits there.

Top module: `soc_trig_prescaler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every channel shows count 0, flag 0 and pulse 0.
- R2: The 3-bit source select per channel takes these codes: 0 = own digital-compare trigger, 1 = counter zero, 2 = counter period, 3 = zero or period, 4 = compare up, 5 = compare down, 6 = compare up or down, 7 = no event. The compare line index is the channel number (A=0, B=1), plus 2 when the alternate-compare bit is set.
- R3: The active period is the 4-bit wide period when the mode bit is 1, and the 2-bit narrow period when it is 0. Each clock edge with a selected event or a force adds one to the count while the count is below the period.
- R4: On an edge where the channel is enabled and the count equals a nonzero period, the pulse output is high for the following cycle and the flag is set. The count restarts at 1 if an event or force is present on that edge, and at 0 otherwise. A set flag never blocks later pulses.
- R5: While the channel is disabled, a count equal to the period holds and no pulse is produced. The pulse follows on the first edge at which the channel is enabled again.
- R6: A period of 0 keeps the count at 0, produces no pulse, and makes force strobes have no effect.
- R7: A force strobe with no selected event advances the count exactly like one event.
- R8: In wide mode with initialisation enabled and a nonzero period, a sync strobe loads the programmed initial value into the count. A force strobe does the same when force-initialisation is selected. A load takes priority over counting and firing. In narrow mode no load happens.
- R9: A clear strobe clears the flag on the next edge, unless a pulse is produced on that same edge; in that case the flag stays set.
- R10: A count above the active period, left behind by a period or mode change, returns to 0 on the next edge that does not load.
- R11: The two channels share no state: strobes and settings of one channel do not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctr_zero | input | 1 | Time-base counter zero event |
| ctr_prd | input | 1 | Time-base counter period event |
| cmp_up | input | 4 | Compare match events while counting up, index 0..3 |
| cmp_dn | input | 4 | Compare match events while counting down, index 0..3 |
| dc_trig | input | 2 | Digital-compare trigger, one per channel |
| sync_in | input | 1 | Sync event, shared |
| trig_sel | input | 2x3 | Source select per channel |
| cmp_alt | input | 2 | Alternate-compare select per channel |
| wide_mode | input | 2 | 1 = 4-bit period, 0 = 2-bit period |
| prd_short | input | 2x2 | Narrow-mode period per channel |
| prd_long | input | 2x4 | Wide-mode period per channel |
| trig_en | input | 2 | Pulse enable per channel |
| init_en | input | 2 | Counter initialisation enable |
| init_on_frc | input | 2 | 1 = force also loads the initial value |
| init_val | input | 2x4 | Initial count value |
| frc | input | 2 | Software force strobe |
| flag_clr | input | 2 | Flag clear strobe |
| trig_pulse | output | 2 | One-cycle start-of-conversion pulse |
| trig_flag | output | 2 | Latched pulse flag |
| trig_count | output | 2x4 | Current event count |

## Verification
A wrong count appears on the count output on the very next cycle. If the error is not caught there, it moves the pulse earlier or later by at least one event, so a mistake in period selection or event selection surfaces within one period of events. A wrong flag or load decision shows one cycle after the strobe that caused it. Pulses that go missing while the channel is disabled only show once the channel is enabled again, when the expected pulse fails to appear on the first edge.

// File: rtl/soc_trig_pkg.sv
package soc_trig_pkg;

  typedef enum logic [2:0] {
    SRC_DC       = 3'd0,
    SRC_ZERO     = 3'd1,
    SRC_PRD      = 3'd2,
    SRC_ZERO_PRD = 3'd3,
    SRC_CMP_UP   = 3'd4,
    SRC_CMP_DN   = 3'd5,
    SRC_CMP_ANY  = 3'd6,
    SRC_NONE     = 3'd7
  } trig_src_e;

  localparam int unsigned SEL_W = 3;

  // Decode one source code into an event hit.
  function automatic logic src_hit(input trig_src_e sel, input logic zero,
                                   input logic prd, input logic up,
                                   input logic dn, input logic dc);
    logic h;
    unique case (sel)
      SRC_DC:       h = dc;
      SRC_ZERO:     h = zero;
      SRC_PRD:      h = prd;
      SRC_ZERO_PRD: h = zero | prd;
      SRC_CMP_UP:   h = up;
      SRC_CMP_DN:   h = dn;
      SRC_CMP_ANY:  h = up | dn;
      default:      h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/soc_evt_select.sv
module soc_evt_select
  import soc_trig_pkg::*;
#(
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned CMP_N = 2 * NUM_CH,
  localparam int unsigned IDX_W = (CMP_N > 1) ? $clog2(CMP_N) : 1
) (
  input  logic             ctr_zero,
  input  logic             ctr_prd,
  input  logic [CMP_N-1:0] cmp_up,
  input  logic [CMP_N-1:0] cmp_dn,
  input  logic             dc_trig,
  input  logic [SEL_W-1:0] sel,
  input  logic             cmp_alt,
  output logic             hit
);

  // Compare line used by this channel: own index, or shifted by NUM_CH.
  function automatic logic [IDX_W-1:0] cmp_index(input logic alt);
    return alt ? IDX_W'(CH_IDX + NUM_CH) : IDX_W'(CH_IDX);
  endfunction

  logic [IDX_W-1:0] ci;
  logic             up_sel;
  logic             dn_sel;

  always_comb begin
    ci     = cmp_index(cmp_alt);
    up_sel = cmp_up[ci];
    dn_sel = cmp_dn[ci];
    hit    = src_hit(trig_src_e'(sel), ctr_zero, ctr_prd, up_sel, dn_sel, dc_trig);
  end

endmodule

// File: rtl/soc_prescale_cnt.sv
module soc_prescale_cnt #(
  parameter int unsigned SHORT_W = 2,
  parameter int unsigned LONG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              frc,
  input  logic              sync_in,
  input  logic              wide,
  input  logic [SHORT_W-1:0] prd_short,
  input  logic [LONG_W-1:0] prd_long,
  input  logic              en,
  input  logic              init_en,
  input  logic              init_on_frc,
  input  logic [LONG_W-1:0] init_val,
  input  logic              clr,
  output logic              pulse,
  output logic              flag,
  output logic [LONG_W-1:0] count,
  output logic              fire,
  output logic              load
);

  function automatic logic [LONG_W-1:0] active_period(input logic w,
      input logic [SHORT_W-1:0] ps, input logic [LONG_W-1:0] pl);
    return w ? pl : LONG_W'(ps);
  endfunction

  // Count after an edge with no load and no fire.
  function automatic logic [LONG_W-1:0] advance(input logic [LONG_W-1:0] c,
      input logic [LONG_W-1:0] p, input logic step);
    logic [LONG_W-1:0] r;
    if (c > p)               r = '0;
    else if (step && c < p)  r = c + LONG_W'(1);
    else                     r = c;
    return r;
  endfunction

  logic [LONG_W-1:0] prd_act;
  logic              prd_zero;
  logic              step;
  logic [LONG_W-1:0] cnt_nxt;

  always_comb begin
    prd_act  = active_period(wide, prd_short, prd_long);
    prd_zero = (prd_act == '0);
    step     = hit | frc;
    load     = !prd_zero && wide && init_en && (sync_in || (frc && init_on_frc));
    fire     = !prd_zero && !load && en && (count == prd_act);
    if (prd_zero)  cnt_nxt = '0;
    else if (load) cnt_nxt = init_val;
    else if (fire) cnt_nxt = step ? LONG_W'(1) : '0;
    else           cnt_nxt = advance(count, prd_act, step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      count <= cnt_nxt;
      pulse <= fire;
      flag  <= fire | (flag & ~clr);
    end
  end

endmodule

// File: rtl/soc_trig_prescaler.sv
module soc_trig_prescaler
  import soc_trig_pkg::*;
#(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned SHORT_W = 2,
  parameter int unsigned LONG_W  = 4,
  localparam int unsigned CMP_N  = 2 * NUM_CH
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ctr_zero,
  input  logic                            ctr_prd,
  input  logic [CMP_N-1:0]                cmp_up,
  input  logic [CMP_N-1:0]                cmp_dn,
  input  logic [NUM_CH-1:0]               dc_trig,
  input  logic                            sync_in,
  input  logic [NUM_CH-1:0][SEL_W-1:0]    trig_sel,
  input  logic [NUM_CH-1:0]               cmp_alt,
  input  logic [NUM_CH-1:0]               wide_mode,
  input  logic [NUM_CH-1:0][SHORT_W-1:0]  prd_short,
  input  logic [NUM_CH-1:0][LONG_W-1:0]   prd_long,
  input  logic [NUM_CH-1:0]               trig_en,
  input  logic [NUM_CH-1:0]               init_en,
  input  logic [NUM_CH-1:0]               init_on_frc,
  input  logic [NUM_CH-1:0][LONG_W-1:0]   init_val,
  input  logic [NUM_CH-1:0]               frc,
  input  logic [NUM_CH-1:0]               flag_clr,
  output logic [NUM_CH-1:0]               trig_pulse,
  output logic [NUM_CH-1:0]               trig_flag,
  output logic [NUM_CH-1:0][LONG_W-1:0]   trig_count
);

  // Named internal events, visible to the bound checker.
  logic [NUM_CH-1:0] hit_vec;
  logic [NUM_CH-1:0] fire_vec;
  logic [NUM_CH-1:0] load_vec;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    soc_evt_select #(
      .CH_IDX (g),
      .NUM_CH (NUM_CH)
    ) i_sel (
      .ctr_zero (ctr_zero),
      .ctr_prd  (ctr_prd),
      .cmp_up   (cmp_up),
      .cmp_dn   (cmp_dn),
      .dc_trig  (dc_trig[g]),
      .sel      (trig_sel[g]),
      .cmp_alt  (cmp_alt[g]),
      .hit      (hit_vec[g])
    );

    soc_prescale_cnt #(
      .SHORT_W (SHORT_W),
      .LONG_W  (LONG_W)
    ) i_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit_vec[g]),
      .frc         (frc[g]),
      .sync_in     (sync_in),
      .wide        (wide_mode[g]),
      .prd_short   (prd_short[g]),
      .prd_long    (prd_long[g]),
      .en          (trig_en[g]),
      .init_en     (init_en[g]),
      .init_on_frc (init_on_frc[g]),
      .init_val    (init_val[g]),
      .clr         (flag_clr[g]),
      .pulse       (trig_pulse[g]),
      .flag        (trig_flag[g]),
      .count       (trig_count[g]),
      .fire        (fire_vec[g]),
      .load        (load_vec[g])
    );
  end

endmodule

// File: rtl/soc_trig_prescaler_chk.sv
module soc_trig_prescaler_chk #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned SHORT_W = 2,
  parameter int unsigned LONG_W  = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH-1:0]              trig_en,
  input logic [NUM_CH-1:0]              flag_clr,
  input logic [NUM_CH-1:0]              wide_mode,
  input logic [NUM_CH-1:0][SHORT_W-1:0] prd_short,
  input logic [NUM_CH-1:0][LONG_W-1:0]  prd_long,
  input logic [NUM_CH-1:0][LONG_W-1:0]  init_val,
  input logic [NUM_CH-1:0]              trig_pulse,
  input logic [NUM_CH-1:0]              trig_flag,
  input logic [NUM_CH-1:0][LONG_W-1:0]  trig_count,
  input logic [NUM_CH-1:0]              fire_vec,
  input logic [NUM_CH-1:0]              load_vec
);

  logic [NUM_CH-1:0][LONG_W-1:0] prd_chk;
  always_comb
    for (int c = 0; c < NUM_CH; c++)
      prd_chk[c] = wide_mode[c] ? prd_long[c] : LONG_W'(prd_short[c]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse[g] |-> trig_flag[g]); // R4
    AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_en[g] && prd_chk[g] != '0 && trig_count[g] == prd_chk[g] && !load_vec[g])
      |=> trig_pulse[g]); // R4
    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse[g] |-> $past(trig_en[g])); // R5
    AST_ZERO_PERIOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prd_chk[g] == '0) |-> (trig_count[g] == '0 && !trig_pulse[g])); // R6
    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_vec[g] |=> trig_count[g] == $past(init_val[g])); // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[g] && !fire_vec[g]) |=> !trig_flag[g]); // R9
  end

endmodule

bind soc_trig_prescaler soc_trig_prescaler_chk #(
  .NUM_CH  (NUM_CH),
  .SHORT_W (SHORT_W),
  .LONG_W  (LONG_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_en    (trig_en),
  .flag_clr   (flag_clr),
  .wide_mode  (wide_mode),
  .prd_short  (prd_short),
  .prd_long   (prd_long),
  .init_val   (init_val),
  .trig_pulse (trig_pulse),
  .trig_flag  (trig_flag),
  .trig_count (trig_count),
  .fire_vec   (fire_vec),
  .load_vec   (load_vec)
);

// File: tb/test_soc_trig_prescaler.sv
module test_soc_trig_prescaler;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            ctr_zero = 0, ctr_prd = 0, sync_in = 0;
  logic [3:0]      cmp_up = '0, cmp_dn = '0;
  logic [1:0]      dc_trig = '0, cmp_alt = '0, wide_mode = '0, trig_en = '0;
  logic [1:0]      init_en = '0, init_on_frc = '0, frc = '0, flag_clr = '0;
  logic [1:0][2:0] trig_sel = '0;
  logic [1:0][1:0] prd_short = '0;
  logic [1:0][3:0] prd_long = '0, init_val = '0;
  logic [1:0]      trig_pulse, trig_flag;
  logic [1:0][3:0] trig_count;

  soc_trig_prescaler i_soc_trig_prescaler (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] m_cnt [2];
  logic       m_flag[2], m_pulse[2];

  function automatic bit sel_hit(int ch);
    int ci = ch + (cmp_alt[ch] ? 2 : 0);
    case (trig_sel[ch])
      3'd0: return dc_trig[ch];
      3'd1: return ctr_zero;
      3'd2: return ctr_prd;
      3'd3: return ctr_zero || ctr_prd;
      3'd4: return cmp_up[ci];
      3'd5: return cmp_dn[ci];
      3'd6: return cmp_up[ci] || cmp_dn[ci];
      default: return 0;
    endcase
  endfunction

  // Reference model of one clock edge, from the requirements.
  task automatic model_edge();
    for (int ch = 0; ch < 2; ch++) begin
      int p = wide_mode[ch] ? int'(prd_long[ch]) : int'(prd_short[ch]);
      int c = int'(m_cnt[ch]);
      bit ev = sel_hit(ch) || frc[ch];
      bit f = 0;
      if (p == 0) c = 0;
      else if (wide_mode[ch] && init_en[ch] && (sync_in || (frc[ch] && init_on_frc[ch])))
        c = int'(init_val[ch]);
      else if (c == p && trig_en[ch]) begin f = 1; c = ev ? 1 : 0; end
      else if (c > p) c = 0;
      else if (ev && c < p) c++;
      m_cnt[ch]   = 4'(c);
      m_pulse[ch] = f;
      m_flag[ch]  = f || (m_flag[ch] && !flag_clr[ch]);
    end
  endtask

  task automatic compare(string tag);
    for (int ch = 0; ch < 2; ch++) begin
      checks++;
      if (trig_count[ch] !== m_cnt[ch] || trig_flag[ch] !== m_flag[ch] ||
          trig_pulse[ch] !== m_pulse[ch]) begin
        errors++;
        $display("FAIL %s ch%0d: got cnt=%0d flag=%b pulse=%b, expected cnt=%0d flag=%b pulse=%b",
                 tag, ch, trig_count[ch], trig_flag[ch], trig_pulse[ch],
                 m_cnt[ch], m_flag[ch], m_pulse[ch]);
      end
    end
  endtask

  task automatic step(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic quiet();
    ctr_zero = 0; ctr_prd = 0; sync_in = 0; cmp_up = '0; cmp_dn = '0;
    dc_trig = '0; frc = '0; flag_clr = '0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0407));
    for (int ch = 0; ch < 2; ch++) begin m_cnt[ch] = 0; m_flag[ch] = 0; m_pulse[ch] = 0; end
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    step("R1 after reset");

    // R2: alternate compare line C (index 2) feeds channel A, line A (0) does not.
    trig_sel[0] = 3'd4; cmp_alt[0] = 1; prd_long[0] = 4'd3; wide_mode[0] = 1; trig_en = 2'b11;
    cmp_up[0] = 1; step("R2 wrong line");
    quiet(); cmp_up[2] = 1; step("R2 alt line", 2);
    quiet(); trig_sel[1] = 3'd0; dc_trig[1] = 1; prd_short[1] = 2'd2; step("R2 dc source", 4);
    quiet();
    // R3/R4: wide period 9, continuous zero events, flag never cleared.
    trig_sel[0] = 3'd1; cmp_alt[0] = 0; prd_long[0] = 4'd9; ctr_zero = 1;
    step("R3 R4 wide count", 25);
    // R3: narrow period 3.
    wide_mode[0] = 0; prd_short[0] = 2'd3; step("R3 narrow", 10);
    // R5: disabled, hold at period, then re-enable.
    trig_en[0] = 0; step("R5 hold", 6);
    ctr_zero = 0; trig_en[0] = 1; step("R5 re-enable", 2);
    // R6: zero period ignores force.
    prd_short[0] = 2'd0; frc[0] = 1; step("R6 zero period", 3);
    frc[0] = 0;
    // R7: force alone counts.
    prd_short[0] = 2'd2; trig_sel[0] = 3'd7; frc[0] = 1; step("R7 force", 5);
    frc[0] = 0;
    // R8: init load on sync and on force; narrow mode ignores it.
    init_en[0] = 1; init_val[0] = 4'd6; sync_in = 1; step("R8 narrow no load");
    wide_mode[0] = 1; prd_long[0] = 4'd8; step("R8 sync load");
    sync_in = 0; init_on_frc[0] = 1; init_val[0] = 4'd2; frc[0] = 1; step("R8 force load");
    frc[0] = 0; init_en[0] = 0;
    // R10: period lowered below count.
    ctr_zero = 1; step("R10 climb", 3); prd_long[0] = 4'd1; step("R10 over", 3);
    // R9: clear coinciding with a pulse and without.
    flag_clr[0] = 1; step("R9 clear", 4); flag_clr[0] = 0; ctr_zero = 0; step("R9 idle", 2);
    trig_en[0] = 0; flag_clr[0] = 1; step("R9 clear alone"); flag_clr[0] = 0;

    // R11 plus random mix.
    for (int i = 0; i < 4000; i++) begin
      quiet();
      if (i % 50 == 0) begin
        trig_sel = {3'($urandom), 3'($urandom)};
        cmp_alt = 2'($urandom); wide_mode = 2'($urandom);
        prd_short = {2'($urandom), 2'($urandom)}; prd_long = {4'($urandom), 4'($urandom)};
        init_en = 2'($urandom); init_on_frc = 2'($urandom);
        init_val = {4'($urandom), 4'($urandom)};
      end
      if ($urandom % 20 == 0) trig_en = 2'($urandom);
      ctr_zero = ($urandom % 3 == 0); ctr_prd = ($urandom % 3 == 0);
      cmp_up = 4'($urandom); cmp_dn = 4'($urandom); dc_trig = 2'($urandom);
      sync_in = ($urandom % 25 == 0);
      for (int ch = 0; ch < 2; ch++) begin
        frc[ch] = ($urandom % 10 == 0); flag_clr[ch] = ($urandom % 8 == 0);
      end
      step("R11 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule